// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It uses 4 KB pages and a two-level translation table held in ordinary memory. Software first sets the root of the table by writing the directory base register. A requester then presents one linear address at a time. The walker makes two dependent reads over a single memory read port. The first read fetches a directory entry, which locates the second-level table. The second read fetches a table entry, which gives the frame base. The walker then adds the untouched page offset to the frame base.

If either entry is marked not present, the walk stops there. The walker returns a fault together with the level at which it stopped, so that a software handler can bring the page in and retry. The memory port may take any number of cycles to answer a read. The walker issues each read as a single-cycle strobe and then waits for the matching response.

Entries are 32 bits wide. Bit 0 is the present flag, bits 31:12 carry the base of the next level or of the frame, and bits 11:1 are not used for translation. A linear address is divided as follows: bits 31:22 select the directory entry, bits 21:12 select the table entry, and bits 11:0 are the byte offset within the page.

Top module: `ptw_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0.
- R2: The first read of a walk goes to address `{base[31:12], 12'h000} + 4 * laddr[31:22]`, where `base` is the directory base register. Every read is a `mem_rd_en` strobe exactly one cycle long, followed by a wait of any length for `mem_rd_valid`.
- R3: When the directory entry has bit 0 set, the second read goes to `{pde[31:12], 12'h000} + 4 * laddr[21:12]`.
- R4: When the table entry has bit 0 set, the walk ends with `done_fault` = 0 and `done_paddr = {pte[31:12], laddr[11:0]}`.
- R5: When the directory entry has bit 0 clear, the walk ends after that single read with `done_fault` = 1 and `done_fault_level` = 0. No second read is made.
- R6: When the table entry has bit 0 clear, the walk ends after two reads with `done_fault` = 1 and `done_fault_level` = 1.
- R7: `done` is a one-cycle pulse that is raised only in the cycle after a read response. `req_ready` is low from the cycle after acceptance until the cycle after the `done` pulse.
- R8: A `req_valid` or `req_laddr` presented while a walk is in progress is ignored. Reads and results follow the accepted address only.
- R9: Bits 11:0 of a directory base write and bits 11:1 of any entry have no effect on read addresses or on the physical address. A new base value applies to the requests that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the directory base register |
| base_wr_data | input | 32 | New directory base; bits 31:12 are kept |
| req_valid | input | 1 | A translation request is presented |
| req_laddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker is idle and takes a request this cycle |
| mem_rd_en | output | 1 | One-cycle read strobe to memory |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: the walk has finished |
| done_fault | output | 1 | With `done`: a not-present entry stopped the walk |
| done_fault_level | output | 1 | With a fault: 0 = directory entry, 1 = table entry |
| done_paddr | output | 32 | With `done` and no fault: the physical address |

## Verification
Random linear addresses are walked over tables whose entries are random words. Present bits are mostly set, so successful translations that check the R2 and R3 address sums are mixed with faults at both levels. This separates a fault at the first level (one read) from a fault at the second level (two reads). Memory latency is drawn anew for every read, so a walker that samples data on a fixed cycle fails where one that waits for the response does not. Directed cases hold a conflicting request during a walk, write base values with junk in the low bits, and place non-zero spare bits in entries. These show whether ignored inputs leak into addresses or results.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W        = 32;
    localparam int PG_OFF_W    = 12;
    localparam int IDX_W       = 10;
    localparam int ENTRY_SHIFT = 2;
    localparam int LEVELS      = 2;
    localparam int FRAME_W     = VA_W - PG_OFF_W;
    localparam int PRESENT_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_READ_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    // Split of a linear address; field order is fixed by the translation.
    typedef struct packed {
        logic [IDX_W-1:0]    dir_idx;
        logic [IDX_W-1:0]    tbl_idx;
        logic [PG_OFF_W-1:0] off;
    } lin_addr_t;

    // Byte address of an entry: table base plus index scaled by entry size.
    function automatic logic [VA_W-1:0] entry_byte_addr(
        input logic [FRAME_W-1:0] tbl_frame,
        input logic [IDX_W-1:0]   idx
    );
        logic [VA_W-1:0] scaled;
        scaled = {{(VA_W-IDX_W-ENTRY_SHIFT){1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
        return {tbl_frame, {PG_OFF_W{1'b0}}} + scaled;
    endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [VA_W-1:0]    addr
);

    always_comb addr = entry_byte_addr(tbl_frame, idx);

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_rd_valid,
    input  logic        rsp_present,
    output walk_state_t state_q,
    output logic        req_ready,
    output logic        accept,
    output logic        rd_en,
    output logic        pde_take,
    output logic        pte_take,
    output logic        done,
    output logic        fault
);

    walk_state_t state_d;
    logic        issued_q;
    logic        in_read;
    logic        rsp_take;

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        in_read   = (state_q == ST_READ_DIR) || (state_q == ST_READ_PTE);
        rd_en     = in_read && !issued_q;
        rsp_take  = in_read && issued_q && mem_rd_valid;
        pde_take  = rsp_take && (state_q == ST_READ_DIR);
        pte_take  = rsp_take && (state_q == ST_READ_PTE);
        done      = (state_q == ST_DONE) || (state_q == ST_FAULT);
        fault     = (state_q == ST_FAULT);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_READ_DIR;
            ST_READ_DIR: if (pde_take) state_d = rsp_present ? ST_READ_PTE : ST_FAULT;
            ST_READ_PTE: if (pte_take) state_d = rsp_present ? ST_DONE : ST_FAULT;
            ST_DONE:     state_d = ST_IDLE;
            ST_FAULT:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rsp_take)   issued_q <= 1'b0;
            else if (rd_en) issued_q <= 1'b1;
        end
    end

    // R7: the completion pulse never lasts two cycles
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: every read strobe is a single cycle
    a_r2_rd_single: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            base_wr_en,
    input  logic [VA_W-1:0] base_wr_data,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_laddr,
    output logic            req_ready,
    output logic            mem_rd_en,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [VA_W-1:0] mem_rd_data,
    output logic            done,
    output logic            done_fault,
    output logic            done_fault_level,
    output logic [VA_W-1:0] done_paddr
);

    walk_state_t        state_q;
    logic               accept;
    logic               pde_take;
    logic               pte_take;
    logic               fault;
    logic               rsp_present;
    logic [FRAME_W-1:0] rsp_frame;

    logic [FRAME_W-1:0] dir_base_q;
    logic [FRAME_W-1:0] tbl_base_q;
    lin_addr_t          laddr_q;
    logic [VA_W-1:0]    paddr_q;
    logic               fault_lvl_q;

    logic [FRAME_W-1:0] lvl_frame [LEVELS];
    logic [IDX_W-1:0]   lvl_idx   [LEVELS];
    logic [VA_W-1:0]    lvl_addr  [LEVELS];

    always_comb begin
        rsp_present = mem_rd_data[PRESENT_BIT];
        rsp_frame   = mem_rd_data[VA_W-1:PG_OFF_W];
        lvl_frame[0] = dir_base_q;
        lvl_idx[0]   = laddr_q.dir_idx;
        lvl_frame[1] = tbl_base_q;
        lvl_idx[1]   = laddr_q.tbl_idx;
    end

    ptw_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .mem_rd_valid (mem_rd_valid),
        .rsp_present  (rsp_present),
        .state_q      (state_q),
        .req_ready    (req_ready),
        .accept       (accept),
        .rd_en        (mem_rd_en),
        .pde_take     (pde_take),
        .pte_take     (pte_take),
        .done         (done),
        .fault        (fault)
    );

    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
        ptw_entry_addr u_addr (
            .tbl_frame (lvl_frame[lvl]),
            .idx       (lvl_idx[lvl]),
            .addr      (lvl_addr[lvl])
        );
    end

    always_comb mem_rd_addr = (state_q == ST_READ_PTE) ? lvl_addr[1] : lvl_addr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_base_q  <= '0;
            tbl_base_q  <= '0;
            laddr_q     <= '0;
            paddr_q     <= '0;
            fault_lvl_q <= 1'b0;
        end else begin
            if (base_wr_en) dir_base_q <= base_wr_data[VA_W-1:PG_OFF_W];
            if (accept)     laddr_q    <= lin_addr_t'(req_laddr);
            if (pde_take) begin
                tbl_base_q  <= rsp_frame;
                fault_lvl_q <= 1'b0;
            end
            if (pte_take) begin
                fault_lvl_q <= 1'b1;
                if (rsp_present) paddr_q <= {rsp_frame, laddr_q.off};
            end
        end
    end

    always_comb begin
        done_fault       = fault;
        done_fault_level = fault && fault_lvl_q;
        done_paddr       = paddr_q;
    end

    // R7: no read is issued while a new request could be taken
    a_r7_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !req_ready);

    // R7: completion follows a memory response by one cycle
    a_r7_done_after_rsp: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_rd_valid));

    // R5: a directory fault reports level 0
    a_r5_dir_fault_level: assert property (@(posedge clk) disable iff (rst)
        (pde_take && !rsp_present) |=> (done_fault && !done_fault_level));

    // R6: a table fault reports level 1
    a_r6_pte_fault_level: assert property (@(posedge clk) disable iff (rst)
        (pte_take && !rsp_present) |=> (done_fault && done_fault_level));

endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done;
    logic        done_fault;
    logic        done_fault_level;
    logic [31:0] done_paddr;

    int checks = 0;
    int failures = 0;
    logic [31:0] cur_base = '0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [$];
    logic        pend = 1'b0;
    int          lat_cnt = 0;

    always #4 clk = ~clk;

    ptw_top u0 (
        .clk(clk), .rst(rst), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .done(done), .done_fault(done_fault),
        .done_fault_level(done_fault_level), .done_paddr(done_paddr)
    );

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] ent_addr(input logic [31:0] tbl, input logic [9:0] idx);
        return {tbl[31:12], 12'h000} + {20'h0, idx, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers each strobe after a random delay of 0..4 extra cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pend) begin
                if (lat_cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = rd_mem(rd_log[rd_log.size()-1]);
                    pend = 1'b0;
                end else begin
                    lat_cnt--;
                end
            end
            if (mem_rd_en && !rst) begin
                pend = 1'b1;
                lat_cnt = int'($urandom % 5);
                rd_log.push_back(mem_rd_addr);
            end
        end
    end

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = v;
        @(negedge clk);
        base_wr_en = 1'b0;
        cur_base = v;
    endtask

    task automatic run_walk(input logic [31:0] la, input bit hold_other);
        logic [31:0] a0, a1, pde, pte, exp_pa;
        int   exp_reads;
        bit   exp_fault, exp_lvl;
        a0 = ent_addr(cur_base, la[31:22]);
        pde = rd_mem(a0);
        a1 = ent_addr(pde, la[21:12]);
        pte = rd_mem(a1);
        exp_pa = {pte[31:12], la[11:0]};
        if (!pde[0]) begin exp_reads = 1; exp_fault = 1; exp_lvl = 0; end
        else if (!pte[0]) begin exp_reads = 2; exp_fault = 1; exp_lvl = 1; end
        else begin exp_reads = 2; exp_fault = 0; exp_lvl = 0; end

        rd_log.delete();
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_laddr = la;
        @(negedge clk);
        if (hold_other) req_laddr = ~la;
        else req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7", "ready low after accept", {31'h0, req_ready}, 32'h0);
        while (!done) @(negedge clk);
        req_valid = 1'b0;

        chk(rd_log.size() == exp_reads, exp_lvl ? "R6" : (exp_fault ? "R5" : "R3"),
            "read count", rd_log.size(), exp_reads);
        if (rd_log.size() > 0)
            chk(rd_log[0] == a0, hold_other ? "R8" : "R2", "directory read addr", rd_log[0], a0);
        if (rd_log.size() > 1 && exp_reads > 1)
            chk(rd_log[1] == a1, "R3", "table read addr", rd_log[1], a1);
        chk(done_fault == exp_fault, exp_fault ? "R5" : "R4", "fault flag",
            {31'h0, done_fault}, {31'h0, exp_fault});
        if (exp_fault)
            chk(done_fault_level == exp_lvl, exp_lvl ? "R6" : "R5", "fault level",
                {31'h0, done_fault_level}, {31'h0, exp_lvl});
        else
            chk(done_paddr == exp_pa, hold_other ? "R8" : "R4", "physical addr", done_paddr, exp_pa);

        @(negedge clk);
        chk(done == 1'b0, "R7", "done pulse width", {31'h0, done}, 32'h0);
        chk(req_ready == 1'b1, "R7", "ready after done", {31'h0, req_ready}, 32'h1);
    endtask

    // Fills the two entries a walk of la would read, with chosen present bits
    task automatic build(input logic [31:0] la, input bit p_dir, input bit p_tbl);
        logic [31:0] a0, a1, v;
        a0 = ent_addr(cur_base, la[31:22]);
        v = $urandom;
        v[0] = p_dir;
        mem[a0] = v;
        a1 = ent_addr(mem[a0], la[21:12]);
        v = $urandom;
        v[0] = p_tbl;
        mem[a1] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] la;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", {31'h0, req_ready}, 32'h1);
        chk(done == 1'b0, "R1", "done after reset", {31'h0, done}, 32'h0);
        chk(mem_rd_en == 1'b0, "R1", "read strobe after reset", {31'h0, mem_rd_en}, 32'h0);

        // R2/R3/R4 directed: simple translation, spare bits clean
        set_base(32'h0003_0000);
        mem[32'h0003_0004] = 32'h0004_5001;
        mem[32'h0004_5008] = 32'h0012_3001;
        run_walk(32'h0040_2ABC, 1'b0);
        chk(done_paddr == 32'h0012_3ABC, "R4", "directed paddr", done_paddr, 32'h0012_3ABC);

        // R9: junk in base low bits and entry spare bits
        set_base(32'h0003_0FFF);
        mem[32'h0003_0FFC] = 32'h0005_0FFF;
        mem[32'h0005_0FFC] = 32'h0077_7FFF;
        run_walk(32'hFFFF_F123, 1'b0);
        chk(done_paddr == 32'h0077_7123, "R9", "ignored low bits", done_paddr, 32'h0077_7123);

        // R5 and R6 directed faults
        la = 32'h1234_5678;
        build(la, 1'b0, 1'b1);
        run_walk(la, 1'b0);
        la = 32'h8765_4321;
        build(la, 1'b1, 1'b0);
        run_walk(la, 1'b0);

        // R8: conflicting request held through the walk
        la = 32'h0ABC_D00E;
        build(la, 1'b1, 1'b1);
        run_walk(la, 1'b1);

        // Random walks with occasional base changes (R9) and random faults
        for (int i = 0; i < 80; i++) begin
            if (i % 10 == 0) set_base($urandom);
            la = $urandom;
            build(la, ($urandom % 8) != 0, ($urandom % 8) != 0);
            run_walk(la, ($urandom % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule